// File: doc/BRIEF.md
# External Interrupt Edge and Flag Unit

This block collects interrupt events from three external pins and five timer sources into one byte of sticky flags, and raises a single combined interrupt request while any flag is set. Each external pin is brought into the clock domain through a synchronizer and then watched for edges. A 2-bit mode field per pin selects which edges count: none, rising only, falling only, or both. Timer events arrive as one-cycle pulses that are already in the block's clock domain, so they go straight to their flags.

Software reaches the block through a small register bus with an address, a write strobe, write data and combinational read data. One address holds the flag byte and another holds the edge-mode byte. Software acknowledges an event by writing 0 to its flag. Writing 1 to a flag leaves it as it is, so a read-modify-write cannot clear an event that software did not see. When a hardware event and a clearing write reach the same bit in the same cycle, the event wins.

The block has no state machine. Its state is the synchronizer and edge-history flops of each pin, the flag register, the mode register and the registered request.

Top module: `ext_irq_flag_unit`

## Requirements
- R1: After reset the flag byte reads 0x00, the mode byte reads 0x00 and `irq` is 0.
- R2: The flag byte is at address 0xBB and the mode byte is at 0xBF. Any other address reads 0x00, and writes to any other address change neither register.
- R3: Flag bit positions: bit 0 is `ext_pin[0]`, bit 1 is `ext_pin[1]`, bit 2 is `ext_pin[2]`, and bits 3 to 7 are `tmr_evt[0]` to `tmr_evt[4]`.
- R4: The mode byte holds one 2-bit field per pin: bits [1:0] for `ext_pin[0]`, bits [3:2] for `ext_pin[1]` and bits [5:4] for `ext_pin[2]`. Code 01 sets the pin's flag on a 0-to-1 transition only.
- R5: Code 10 sets the pin's flag on a 1-to-0 transition only.
- R6: Code 11 sets the pin's flag on either transition.
- R7: Code 00 sets the flag on no transition.
- R8: A set flag stays set until software writes 0 to that bit at 0xBB. Writing 1 to a bit leaves it unchanged.
- R9: If a source event and a write of 0 reach the same flag bit in the same cycle, the bit ends at 1.
- R10: Mode bits 7 and 6 always read 0, and writes to them have no effect.
- R11: `irq` is registered. It is 1 in the cycle after any flag is 1 and 0 in the cycle after all flags are 0.
- R12: A pin level present at clock edge k sets the flag at edge k+2, if it makes a selected transition. A timer pulse present at edge k sets its flag at edge k.
- R13: Writing a new mode code never sets a flag by itself. The edge history keeps following the pin while the code is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 3 | Asynchronous external interrupt pins |
| tmr_evt | input | 5 | One-cycle timer event pulses, same clock domain |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq | output | 1 | Combined interrupt request, registered |

## Verification
Each result has a fixed latency. A register write takes effect at the edge that samples it. A timer pulse shows in the flag byte at the edge that samples it. A pin change shows two edges after it is first sampled, and `irq` follows the flags one edge later. The bench changes its inputs on falling clock edges and samples on falling edges, so every result is read at a known number of rising edges after its cause. Directed sequences count those edges one by one and check that the flag is still 0 one edge before it is due. The random phase keeps a cycle-stepped model of these latencies and compares against it every cycle.

// File: rtl/eiu_pkg.sv
package eiu_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    localparam int MODE_W = 2;

endpackage

// File: rtl/eiu_edge_detect.sv
module eiu_edge_detect
    import eiu_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin,
    input  logic [MODE_W-1:0]   mode,
    output logic                hit
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              now_s;
    logic              rise;
    logic              fall;
    edge_mode_e        sel;

    assign now_s = sync_q[STAGES-1];
    assign sel   = edge_mode_e'(mode);

    // synchronizer chain and edge history; history follows the pin in every mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= now_s;
        end
    end

    always_comb begin
        rise = now_s & ~prev_q;
        fall = ~now_s & prev_q;
        hit  = 1'b0;
        unique case (sel)
            EDGE_NONE: hit = 1'b0;
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
        endcase
    end

endmodule

// File: rtl/eiu_mode_reg.sv
module eiu_mode_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mode_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q <= wdata;
        end
    end

endmodule

// File: rtl/eiu_flag_reg.sv
module eiu_flag_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_en,
    input  logic [W-1:0] keep_mask,
    output logic [W-1:0] flag_q,
    output logic         irq_q
);

    logic [W-1:0] flag_d;

    // a write keeps only the bits written as 1; a same-cycle event overrides the clear
    always_comb begin
        flag_d = clr_en ? (flag_q & keep_mask) : flag_q;
        flag_d = flag_d | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            irq_q  <= |flag_q;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !(clr_en && !keep_mask[i])) |=> flag_q[i]); // R8
        AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flag_q[i]); // R9
        AST_ONE_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && keep_mask[i] && !set_vec[i]) |=> (flag_q[i] == $past(flag_q[i]))); // R8
    end

    AST_IRQ_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q != '0) |=> irq_q); // R11
    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q == '0) |=> !irq_q); // R11

endmodule

// File: rtl/ext_irq_flag_unit.sv
module ext_irq_flag_unit
    import eiu_pkg::*;
#(
    parameter int                N_EXT       = 3,
    parameter int                N_TMR       = 5,
    parameter int                SYNC_STAGES = 2,
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR   = 8'hBB,
    parameter logic [ADDR_W-1:0] MODE_ADDR   = 8'hBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_pin,
    input  logic [N_TMR-1:0]  tmr_evt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int FLAG_W = N_EXT + N_TMR;
    localparam int MODE_T = N_EXT * MODE_W;

    logic [N_EXT-1:0]  ext_hit;
    logic [MODE_T-1:0] mode_q;
    logic [FLAG_W-1:0] flag_q;
    logic              wr_flag;
    logic              wr_mode;

    assign wr_flag = bus_wr && (bus_addr == FLAG_ADDR);
    assign wr_mode = bus_wr && (bus_addr == MODE_ADDR);

    for (genvar i = 0; i < N_EXT; i++) begin : g_pin
        eiu_edge_detect #(
            .STAGES (SYNC_STAGES)
        ) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_pin[i]),
            .mode  (mode_q[MODE_W*i +: MODE_W]),
            .hit   (ext_hit[i])
        );
    end

    eiu_mode_reg #(
        .W (MODE_T)
    ) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_mode),
        .wdata  (bus_wdata[MODE_T-1:0]),
        .mode_q (mode_q)
    );

    eiu_flag_reg #(
        .W (FLAG_W)
    ) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   ({tmr_evt, ext_hit}),
        .clr_en    (wr_flag),
        .keep_mask (bus_wdata[FLAG_W-1:0]),
        .flag_q    (flag_q),
        .irq_q     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == FLAG_ADDR) begin
            bus_rdata[FLAG_W-1:0] = flag_q;
        end else if (bus_addr == MODE_ADDR) begin
            bus_rdata[MODE_T-1:0] = mode_q;
        end
    end

    for (genvar i = 0; i < N_EXT; i++) begin : g_pin_chk
        AST_DISABLED_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[i]) |-> ($past(mode_q[MODE_W*i +: MODE_W]) != 2'b00)); // R7
    end

    AST_MODE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == MODE_ADDR) |-> (bus_rdata[DATA_W-1:MODE_T] == '0)); // R10

endmodule

// File: tb/test_ext_irq_flag_unit.sv
module test_ext_irq_flag_unit;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_FLAG = 8'hBB;
    localparam logic [7:0] A_MODE = 8'hBF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ext_pin = '0;
    logic [4:0] tmr_evt = '0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // cycle-stepped expectation built from the requirements
    logic [7:0] m_flag = '0;
    logic [5:0] m_mode = '0;
    logic [2:0] m_h0 = '0, m_h1 = '0, m_h2 = '0;
    logic       m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_flag_unit i_ext_irq_flag_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin   (ext_pin),
        .tmr_evt   (tmr_evt),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [2:0] pin_hits(input logic [2:0] cur, input logic [2:0] old,
                                            input logic [5:0] md);
        logic [2:0] h;
        for (int i = 0; i < 3; i++) begin
            h[i] = (md[2*i] & cur[i] & ~old[i]) | (md[2*i+1] & ~cur[i] & old[i]);
        end
        return h;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == A_FLAG) return m_flag;
        if (a == A_MODE) return {2'b00, m_mode};
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        logic [7:0] nf;
        if (!rst_n) begin
            m_flag = '0; m_mode = '0; m_irq = 1'b0;
            m_h0 = '0; m_h1 = '0; m_h2 = '0;
        end else begin
            nf = (bus_wr && bus_addr == A_FLAG) ? (m_flag & bus_wdata) : m_flag;
            nf = nf | {tmr_evt, pin_hits(m_h1, m_h2, m_mode)};
            m_irq = |m_flag;
            m_flag = nf;
            if (bus_wr && bus_addr == A_MODE) m_mode = bus_wdata[5:0];
            m_h2 = m_h1; m_h1 = m_h0; m_h0 = ext_pin;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED_0001));
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_FLAG, d); chk("R1 flags", d, 8'h00);
        rd(A_MODE, d); chk("R1 mode", d, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);

        // R10 unused mode bits
        wr(A_MODE, 8'hFF);
        rd(A_MODE, d); chk("R10 mode top bits", d, 8'h3F);

        // R4 rising edge on ext_pin[0], with R12 and R11 timing
        wr(A_MODE, 8'h01);
        ext_pin[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(A_FLAG, d); chk("R12 pin flag not early", d, 8'h00);
        @(negedge clk);
        rd(A_FLAG, d); chk("R4 R12 rising sets bit0", d, 8'h01);
        chk("R11 irq one edge late", {7'b0, irq}, 8'h00);
        @(negedge clk);
        chk("R11 irq raised", {7'b0, irq}, 8'h01);

        // R8 write one holds, write zero clears
        wr(A_FLAG, 8'hFF);
        rd(A_FLAG, d); chk("R8 write one keeps", d, 8'h01);
        wr(A_FLAG, 8'hFE);
        rd(A_FLAG, d); chk("R8 write zero clears", d, 8'h00);

        // R4 falling transition ignored in rising mode
        ext_pin[0] = 1'b0;
        wait_n(4);
        rd(A_FLAG, d); chk("R4 fall ignored", d, 8'h00);

        // R7 disabled pin, R13 mode change does not set
        wr(A_MODE, 8'h00);
        ext_pin[1] = 1'b1;
        wait_n(4);
        rd(A_FLAG, d); chk("R7 code 00 silent", d, 8'h00);
        wr(A_MODE, 8'h04);
        wait_n(4);
        rd(A_FLAG, d); chk("R13 no flag from mode write", d, 8'h00);

        // R5 falling mode on ext_pin[1]
        wr(A_MODE, 8'h08);
        ext_pin[1] = 1'b0;
        wait_n(4);
        rd(A_FLAG, d); chk("R5 falling sets bit1", d, 8'h02);
        wr(A_FLAG, 8'h00);

        // R6 both edges on ext_pin[2]
        wr(A_MODE, 8'h30);
        ext_pin[2] = 1'b1;
        wait_n(4);
        rd(A_FLAG, d); chk("R6 rise sets bit2", d, 8'h04);
        wr(A_FLAG, 8'h00);
        ext_pin[2] = 1'b0;
        wait_n(4);
        rd(A_FLAG, d); chk("R6 fall sets bit2", d, 8'h04);
        wr(A_FLAG, 8'h00);

        // R3 R12 timer pulse lands at the sampling edge
        tmr_evt = 5'b10000;
        @(negedge clk);
        tmr_evt = '0;
        rd(A_FLAG, d); chk("R3 R12 timer4 to bit7", d, 8'h80);

        // R9 event beats clearing write
        tmr_evt = 5'b00001;
        bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'h00;
        @(negedge clk);
        bus_wr = 1'b0; tmr_evt = '0;
        rd(A_FLAG, d); chk("R9 set wins over clear", d, 8'h08);

        // R2 other addresses
        wr(8'h10, 8'hAA);
        rd(8'h10, d); chk("R2 other reads zero", d, 8'h00);
        rd(A_FLAG, d); chk("R2 flags untouched", d, 8'h08);
        rd(A_MODE, d); chk("R2 mode untouched", d, 8'h30);
        wr(A_FLAG, 8'h00);

        // random phase against the cycle-stepped expectation (R3 to R13)
        for (int c = 0; c < 4000; c++) begin
            int op;
            chk("R11 irq random", {7'b0, irq}, {7'b0, m_irq});
            #1;
            chk("R2 R3 R8 R12 read random", bus_rdata, exp_read(bus_addr));
            if ($urandom % 3 == 0) ext_pin = ext_pin ^ 3'($urandom);
            tmr_evt = ($urandom % 6 == 0) ? 5'($urandom) : 5'b0;
            op = int'($urandom % 8);
            bus_wdata = 8'($urandom);
            if (op == 0) begin
                bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = bus_wdata & 8'($urandom);
            end else if (op == 1) begin
                bus_wr = 1'b1; bus_addr = A_MODE;
            end else begin
                bus_wr = 1'b0;
                bus_addr = (op < 5) ? A_FLAG : (op == 5) ? A_MODE : 8'($urandom);
            end
            @(negedge clk);
        end
        bus_wr = 1'b0;
        finish_run();
    end

endmodule